// File: doc/BRIEF.md
# Transport Stream Energy Dispersal Scrambler

This block sits at the head of a broadcast channel coder. It takes a byte stream of fixed-length transport packets. Each byte comes with a valid strobe, and the first byte of each packet also carries a start strobe. The block counts packets into groups of eight, called superframes. It replaces the leading byte of the first packet in each group with its bitwise inverse, so the receiver can find the group boundary.

Every byte that is not a packet-leading byte is XORed with a pseudo-random sequence. The sequence generator is reloaded with a fixed seed at each group boundary, and it runs by itself, so the output spectrum stays flat whatever the payload. Leading bytes are never XORed. At a normal leading byte the generator still steps through the eight positions it would have used, but its output is not applied. At the inverted leading byte it is reloaded instead.

After the last byte of each full packet, the block produces a run of zero placeholder bytes, flagged as such. This lets a later parity encoder see a fixed slot that is longer than the packet. The upstream source keeps those slots free. Anything it offers during the placeholder run is dropped. All outputs are registered, one cycle behind the input.

Top module: `tsd_scrambler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_start, out_gap and out_byte are all zero.
- R2: An input byte taken with in_valid=1 appears on the outputs exactly one clock later with out_valid=1. A byte taken with in_valid=1 and in_start=1 outside a placeholder run is a packet-leading byte, and it comes out with out_start=1.
- R3: Packet-leading bytes are numbered 0 to 7 cyclically, counting from reset. Leading byte number 0 is output as the bitwise inverse of its input (0x47 becomes 0xB8). Leading bytes 1 to 7 are output unchanged.
- R4: Every non-leading byte of a packet is output as its input XOR the next 8 bits of the sequence generator, with the earliest bit on bit 7. The generator is a 15-stage shift register for 1 + x^14 + x^15, where a new bit = stage14 XOR stage15, and that new bit both enters stage 1 and is the output bit. The first data byte after a reload is XORed with 0x03.
- R5: Packet-leading bytes 1 to 7 are not XORed, but the generator steps 8 bits across each of them.
- R6: At each leading byte number 0, the generator is loaded with stages 1 to 15 = 100101010000000. The first data byte of every superframe is therefore XORed with 0x03.
- R7: After the 188th byte of a packet, the outputs show 16 consecutive cycles with out_valid=1, out_gap=1, out_start=0 and out_byte=0x00.
- R8: in_valid, in_start and in_byte have no effect during the 16 placeholder cycles. Those bytes are dropped, and the generator, the packet count and the byte count do not move.
- R9: The generator does not step on placeholder or idle cycles. Idle cycles inside a packet leave the following output bytes unchanged.
- R10: A cycle with in_valid=0 outside a placeholder run gives out_valid=0, out_start=0, out_gap=0 and out_byte=0 one clock later.
- R11: A byte offered with in_valid=1 and in_start=0 while no packet is open (for example after reset, or after a placeholder run) is dropped, with out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the leading byte of a packet |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_start | output | 1 | Marks an output packet-leading byte |
| out_gap | output | 1 | Marks a placeholder byte |
| out_byte | output | 8 | Output byte |

## Verification
The bench builds the block with its default parameters: 188-byte packets, 16 placeholder bytes, groups of eight and a byte width of 8. With these values a single run covers twenty packets, which is more than two full superframes, so the reload at the second group boundary is checked against the fixed first sequence byte 0x03. Random idle cycles inside packets, random strobes during placeholder runs and a non-standard leading byte together exercise the generator hold, the dropped-input rules and the bitwise inversion.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

   // Per-cycle classification of the input slot
   typedef enum logic [2:0] {
      SLOT_IDLE     = 3'd0,
      SLOT_SYNC_INV = 3'd1,
      SLOT_SYNC     = 3'd2,
      SLOT_DATA     = 3'd3,
      SLOT_GAP      = 3'd4
   } slot_e;

   localparam int SEQ_STAGES = 15;

   // Seed with stage 1 on bit 0: stages 1,4,6,8 set
   localparam logic [SEQ_STAGES-1:0] SEQ_SEED = 15'h00A9;

endpackage

// File: rtl/tsd_framer.sv
module tsd_framer
   import tsd_pkg::*;
#(
   parameter int PKT_LEN = 188,
   parameter int GAP_LEN = 16,
   parameter int GROUP   = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_valid,
   input  logic  in_start,
   output slot_e slot
);

   localparam int POS_W = $clog2(PKT_LEN);
   localparam int GAP_W = $clog2(GAP_LEN + 1);
   localparam int GRP_W = $clog2(GROUP);

   generate
      if (PKT_LEN < 2) begin : g_bad_pkt
         $error("tsd_framer: PKT_LEN must be at least 2");
      end
      if (GAP_LEN < 1) begin : g_bad_gap
         $error("tsd_framer: GAP_LEN must be at least 1");
      end
      if (GROUP < 2) begin : g_bad_grp
         $error("tsd_framer: GROUP must be at least 2");
      end
   endgenerate

   logic [POS_W-1:0] pos;
   logic [GAP_W-1:0] gap_cnt;
   logic [GRP_W-1:0] grp;
   logic             in_pkt;

   always_comb begin
      if (gap_cnt != '0)
         slot = SLOT_GAP;
      else if (in_valid && in_start)
         slot = (grp == '0) ? SLOT_SYNC_INV : SLOT_SYNC;
      else if (in_valid && in_pkt)
         slot = SLOT_DATA;
      else
         slot = SLOT_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         gap_cnt <= '0;
         grp     <= '0;
         in_pkt  <= 1'b0;
      end else begin
         unique case (slot)
            SLOT_GAP: gap_cnt <= gap_cnt - GAP_W'(1);
            SLOT_SYNC_INV, SLOT_SYNC: begin
               grp    <= (grp == GRP_W'(GROUP - 1)) ? '0 : grp + GRP_W'(1);
               pos    <= POS_W'(1);
               in_pkt <= 1'b1;
            end
            SLOT_DATA: begin
               if (pos == POS_W'(PKT_LEN - 1)) begin
                  pos     <= '0;
                  in_pkt  <= 1'b0;
                  gap_cnt <= GAP_W'(GAP_LEN);
               end else begin
                  pos <= pos + POS_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   // A placeholder run never overlaps an open packet
   assert_gap_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_cnt != '0) |-> !in_pkt);

   // Byte position stays inside the packet
   assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, pos} < (POS_W + 1)'(PKT_LEN));

endmodule

// File: rtl/tsd_prbs.sv
module tsd_prbs
   import tsd_pkg::*;
#(
   parameter int W     = 8,
   parameter int TAP_A = 14,
   parameter int TAP_B = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         advance,
   output logic [W-1:0] mask
);

   localparam int N = SEQ_STAGES;

   generate
      if (TAP_B != N || TAP_A >= TAP_B || TAP_A < 1) begin : g_bad_taps
         $error("tsd_prbs: taps must satisfy 1 <= TAP_A < TAP_B == stages");
      end
      if (W < 1) begin : g_bad_w
         $error("tsd_prbs: W must be positive");
      end
   endgenerate

   logic [N-1:0] state;
   logic [N-1:0] chain [0:W];

   assign chain[0] = state;

   // Unrolled W steps; earliest bit lands on the top mask bit
   generate
      for (genvar g = 0; g < W; g++) begin : g_step
         logic fb;
         assign fb           = chain[g][TAP_A-1] ^ chain[g][TAP_B-1];
         assign chain[g+1]   = {chain[g][N-2:0], fb};
         assign mask[W-1-g]  = fb;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SEQ_SEED;
      else if (load)
         state <= SEQ_SEED;
      else if (advance)
         state <= chain[W];
   end

   assert_load_adv_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load, advance}));

   assert_state_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/tsd_scrambler.sv
module tsd_scrambler
   import tsd_pkg::*;
#(
   parameter int PKT_LEN = 188,
   parameter int GAP_LEN = 16,
   parameter int GROUP   = 8,
   parameter int W       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic [W-1:0] in_byte,
   output logic         out_valid,
   output logic         out_start,
   output logic         out_gap,
   output logic [W-1:0] out_byte
);

   slot_e        slot;
   logic [W-1:0] mask;
   logic         seq_load;
   logic         seq_step;

   tsd_framer #(
      .PKT_LEN (PKT_LEN),
      .GAP_LEN (GAP_LEN),
      .GROUP   (GROUP)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_start (in_start),
      .slot     (slot)
   );

   assign seq_load = (slot == SLOT_SYNC_INV);
   assign seq_step = (slot == SLOT_DATA) || (slot == SLOT_SYNC);

   tsd_prbs #(
      .W (W)
   ) u_prbs (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seq_load),
      .advance (seq_step),
      .mask    (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_start <= 1'b0;
         out_gap   <= 1'b0;
         out_byte  <= '0;
      end else begin
         out_valid <= (slot != SLOT_IDLE);
         out_start <= (slot == SLOT_SYNC_INV) || (slot == SLOT_SYNC);
         out_gap   <= (slot == SLOT_GAP);
         unique case (slot)
            SLOT_SYNC_INV: out_byte <= ~in_byte;
            SLOT_SYNC:     out_byte <= in_byte;
            SLOT_DATA:     out_byte <= in_byte ^ mask;
            default:       out_byte <= '0;
         endcase
      end
   end

   assert_gap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_gap |-> (out_valid && !out_start && out_byte == '0));

   assert_sync_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> (out_byte == $past(in_byte) || out_byte == ~$past(in_byte)));

   assert_gap_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_gap) |-> $past(out_valid && !out_start));

   assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);

endmodule

// File: tb/tsd_scrambler_tb.sv
`timescale 1ns/1ps
module tsd_scrambler_tb;

   localparam int PKT = 188;
   localparam int GAP = 16;
   localparam int GRP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_start = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_start, out_gap;
   logic [7:0] out_byte;

   int checks = 0;
   int errors = 0;

   // Bench reference model state
   int          m_gap = 0;
   int          m_pos = 0;
   int          m_grp = 0;
   bit          m_open = 1'b0;
   logic [14:0] m_seq = 15'h00A9;

   always #2 clk = ~clk;

   tsd_scrambler u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .in_byte   (in_byte),
      .out_valid (out_valid),
      .out_start (out_start),
      .out_gap   (out_gap),
      .out_byte  (out_byte)
   );

   function automatic logic [7:0] seq_next(inout logic [14:0] st);
      logic [7:0] r = 8'h00;
      for (int i = 0; i < 8; i++) begin
         logic b = st[13] ^ st[14];
         st = {st[13:0], b};
         r  = {r[6:0], b};
      end
      return r;
   endfunction

   task automatic chk(string tag, bit ev, bit es, bit eg, logic [7:0] eb);
      checks++;
      if (out_valid !== ev || out_start !== es || out_gap !== eg || out_byte !== eb) begin
         errors++;
         $display("FAIL %s: got v=%0d s=%0d g=%0d b=%02h expected v=%0d s=%0d g=%0d b=%02h",
                  tag, out_valid, out_start, out_gap, out_byte, ev, es, eg, eb);
      end
   endtask

   // Drive one cycle at the falling edge, check the registered result one edge later
   task automatic step(bit v, bit s, logic [7:0] b);
      bit ev = 0, es = 0, eg = 0;
      logic [7:0] eb = 8'h00;
      logic [7:0] m;
      string tag;
      if (m_gap > 0) begin
         ev = 1; eg = 1; m_gap--;
         tag = v ? "R8" : "R7";
      end else if (v && s) begin
         ev = 1; es = 1;
         if (m_grp == 0) begin
            eb = ~b; m_seq = 15'h00A9; tag = "R2 R3";
         end else begin
            eb = b; m = seq_next(m_seq); tag = "R2 R5";
         end
         m_grp = (m_grp + 1) % GRP;
         m_open = 1; m_pos = 1;
      end else if (v && m_open) begin
         ev = 1;
         m  = seq_next(m_seq);
         eb = b ^ m; tag = "R4";
         m_pos++;
         if (m_pos == PKT) begin
            m_open = 0; m_gap = GAP;
         end
      end else begin
         tag = v ? "R11" : (m_open ? "R9" : "R10");
      end
      in_valid = v; in_start = s; in_byte = b;
      @(posedge clk);
      @(negedge clk);
      chk(tag, ev, es, eg, eb);
   endtask

   task automatic send_packet(logic [7:0] sync, int idle_pct, bit zero_first, string ztag);
      step(1, 1, sync);
      for (int i = 1; i < PKT; i++) begin
         logic [7:0] b;
         while ($urandom_range(99) < idle_pct)
            step(0, 1'($urandom_range(1)), 8'($urandom));
         b = (i == 1 && zero_first) ? 8'h00 : 8'($urandom);
         step(1, 0, b);
         if (i == 1 && zero_first) begin
            checks++;
            if (out_byte !== 8'h03) begin
               errors++;
               $display("FAIL %s: first sequence byte got %02h expected 03", ztag, out_byte);
            end
         end
      end
      // Placeholder run: random strobes must be dropped
      for (int g = 0; g < GAP; g++)
         step(1'($urandom_range(1)), 1'($urandom_range(1)), 8'($urandom));
      for (int k = $urandom_range(3); k > 0; k--)
         step(0, 0, 8'h00);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", 0, 0, 0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 0, 0, 0, 8'h00);
      // Orphan bytes before any packet start
      for (int i = 0; i < 5; i++)
         step(1, 0, 8'($urandom));
      step(0, 0, 8'h00);
      for (int p = 0; p < 20; p++) begin
         logic [7:0] sy = (p == 3) ? 8'h5A : 8'h47;
         int pct = (p % 3 == 1) ? 10 : 0;
         send_packet(sy, pct, (p == 0) || (p == 8) || (p == 16),
                     (p == 0) ? "R4" : "R6");
         if (p == 5)
            for (int i = 0; i < 3; i++)
               step(1, 0, 8'($urandom));
      end
      repeat (2) step(0, 0, 8'h00);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule